// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block is the control core of a receive DMA that works through a ring of descriptors held in system memory. It reads word 0 of each descriptor through a one-outstanding request/acknowledge memory port, checks who owns it, hands owned buffers to the receive FIFO side segment by segment, and hands each descriptor back to the host by writing word 0 with ownership cleared and the segment flags set. It always tries to have the next descriptor in hand before a frame needs it.

The engine shows three visible states: stopped, running and suspended. When it meets a host-owned descriptor it signals buffer-unavailable, suspends and keeps its place in the ring. While suspended, a new frame or a poll demand makes it read the same descriptor again. If the host still owns it, a frame waiting at the FIFO head is either discarded and counted as missed, or left in place, depending on the flush-disable input. A stop command takes effect only once no memory access is outstanding.

Top module: `rxdesc_engine`

## Requirements
- R1: After reset the engine is stopped (state_o = 0), issues no memory request, asserts no transfer enable and the missed-frame count is 0.
- R2: A start pulse in the stopped state makes the engine read the descriptor at ring_base_i, with mem_req_o high and mem_we_o low in the cycle after the pulse, before any frame arrives.
- R3: Descriptor word 0 bit 31 set means the engine owns it. After reading an owned descriptor the engine is running (state_o = 1) and holds it, and asserts xfer_o only once frame_rdy_i is high.
- R4: A segment-done pulse closes the current descriptor. Its write-back keeps bits 30..10 and 7..0 of the word that was read, clears bit 31, sets bit 9 only on the first segment of a frame and bit 8 only on the last, so a one-segment frame has both bits set.
- R5: Each close first reads the next descriptor and then writes back the closed one. rx_done_o pulses once, in the cycle after the acknowledge of the write-back that carries bit 8.
- R6: The next descriptor address is the current address plus DESC_BYTES, or ring_base_i when bit 15 of the current descriptor's word 0 is set.
- R7: Reading a host-owned descriptor with no write-back pending raises buf_unavail_o for exactly the cycle after the read acknowledge, and the engine then shows the suspended state (state_o = 2) with cur_addr_o unchanged.
- R8: While suspended, a frame_arrive_i or poll_i pulse makes the engine read the same descriptor again. If it is now owned, the engine runs and receives the waiting frame into that descriptor.
- R9: When that read finds the descriptor host-owned, a frame is waiting and flush_dis_i is low, the engine pulses flush_o once and adds one to missed_o, then repeats the read and discard for every frame still waiting before returning to suspended.
- R10: With flush_dis_i high, a host-owned read never pulses flush_o, leaves missed_o unchanged and the waiting frame in place, raises buf_unavail_o again and stays suspended.
- R11: missed_o saturates at 2^MISS_W - 1.
- R12: A stop pulse moves the engine to the stopped state only after an access already in progress is acknowledged, and a write-back in progress lands in memory. No request follows.
- R13: Once raised, mem_req_o stays high with the same address and direction until mem_ack_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start-receive pulse |
| stop_i | input | 1 | Stop-receive pulse |
| poll_i | input | 1 | Poll demand pulse |
| flush_dis_i | input | 1 | When high, host-owned descriptors never discard frames |
| ring_base_i | input | AW | Address of the first descriptor of the ring |
| frame_arrive_i | input | 1 | Pulse: a new frame was stored in the FIFO |
| frame_rdy_i | input | 1 | A frame is waiting at the FIFO head |
| seg_done_i | input | 1 | Pulse: the current buffer segment has been written |
| seg_last_i | input | 1 | Qualifies seg_done_i: that segment ended the frame |
| xfer_o | output | 1 | Current buffer may be filled by the FIFO side |
| flush_o | output | 1 | Discard the frame at the FIFO head |
| mem_req_o | output | 1 | Descriptor memory request |
| mem_we_o | output | 1 | Request is a write-back |
| mem_addr_o | output | AW | Descriptor address |
| mem_wdata_o | output | 32 | Word 0 written back |
| mem_ack_i | input | 1 | Memory acknowledge, ends the access |
| mem_rdata_i | input | 32 | Word 0 read |
| state_o | output | 2 | 0 stopped, 1 running, 2 suspended |
| rx_done_o | output | 1 | Receive-complete status pulse |
| buf_unavail_o | output | 1 | Buffer-unavailable status pulse |
| missed_o | output | MISS_W | Saturating missed-frame count |
| cur_addr_o | output | AW | Address of the current descriptor |

## Verification
Every access takes one cycle plus the memory model's wait states. The read request appears the cycle after a start pulse, buf_unavail_o rises the cycle after the acknowledge of a host-owned read, and rx_done_o rises the cycle after the acknowledge of a last-segment write-back. The bench's memory model samples requests at the falling edge and checks those single-cycle delays at the following falling edge. Outcomes that take several accesses (descriptor contents, ring position, missed count, state) are compared after a settling window long enough for the slowest chain of accesses, because their cycle count depends on the wait states.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    localparam int OWN_BIT = 31;
    localparam int EOR_BIT = 15;
    localparam int FS_BIT  = 9;
    localparam int LS_BIT  = 8;

    typedef enum logic [1:0] {
        VIS_STOP = 2'd0,
        VIS_RUN  = 2'd1,
        VIS_SUSP = 2'd2
    } vis_state_t;

    typedef enum logic [2:0] {
        ST_STOP,
        ST_FETCH,
        ST_READY,
        ST_RECV,
        ST_WB,
        ST_SUSP,
        ST_FLUSH,
        ST_FLWAIT
    } eng_state_t;

endpackage

// File: rtl/rxd_ring_step.sv
module rxd_ring_step #(
    parameter int AW         = 16,
    parameter int DESC_BYTES = 16
) (
    input  logic [AW-1:0] cur_i,
    input  logic [AW-1:0] base_i,
    input  logic          wrap_i,
    output logic [AW-1:0] next_o
);
    localparam logic [AW-1:0] STRIDE = AW'(DESC_BYTES);

    always_comb begin
        if (wrap_i) begin
            next_o = base_i;
        end else begin
            next_o = cur_i + STRIDE;
        end
    end
endmodule

// File: rtl/rxd_sat_cnt.sv
module rxd_sat_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc_i && (cnt_q != TOP)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt_q) == TOP) |-> (cnt_q == TOP)); // R11
endmodule

// File: rtl/rxdesc_engine.sv
module rxdesc_engine
    import rxd_pkg::*;
#(
    parameter int AW         = 16,
    parameter int DESC_BYTES = 16,
    parameter int MISS_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              poll_i,
    input  logic              flush_dis_i,
    input  logic [AW-1:0]     ring_base_i,
    input  logic              frame_arrive_i,
    input  logic              frame_rdy_i,
    input  logic              seg_done_i,
    input  logic              seg_last_i,
    output logic              xfer_o,
    output logic              flush_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [AW-1:0]     mem_addr_o,
    output logic [31:0]       mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [31:0]       mem_rdata_i,
    output logic [1:0]        state_o,
    output logic              rx_done_o,
    output logic              buf_unavail_o,
    output logic [MISS_W-1:0] missed_o,
    output logic [AW-1:0]     cur_addr_o
);

    typedef struct packed {
        eng_state_t    st;
        logic [AW-1:0] cur;
        logic [AW-1:0] prev;
        logic [30:0]   cur_word;
        logic [30:0]   prev_word;
        logic          prev_fs;
        logic          prev_ls;
        logic          first;
        logic          wb_pend;
        logic          nxt_own;
        logic          stop_pend;
        logic          rx_done;
        logic          ru;
    } eng_t;

    eng_t          d, q;
    logic [AW-1:0] next_addr;
    logic          rd_own;
    logic [31:0]   wb_word;
    vis_state_t    vis;

    assign rd_own = mem_rdata_i[OWN_BIT];

    rxd_ring_step #(
        .AW         (AW),
        .DESC_BYTES (DESC_BYTES)
    ) u_step (
        .cur_i  (q.cur),
        .base_i (ring_base_i),
        .wrap_i (q.cur_word[EOR_BIT]),
        .next_o (next_addr)
    );

    rxd_sat_cnt #(
        .W (MISS_W)
    ) u_miss (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (flush_o),
        .cnt_o (missed_o)
    );

    always_comb begin
        d           = q;
        d.rx_done   = 1'b0;
        d.ru        = 1'b0;
        d.stop_pend = q.stop_pend | stop_i;

        case (q.st)
            ST_STOP: begin
                if (start_i) begin
                    d.cur     = ring_base_i;
                    d.wb_pend = 1'b0;
                    d.st      = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (mem_ack_i) begin
                    d.cur_word = mem_rdata_i[30:0];
                    if (q.wb_pend) begin
                        d.nxt_own = rd_own;
                        d.st      = ST_WB;
                    end else if (d.stop_pend) begin
                        d.st = ST_STOP;
                    end else if (rd_own) begin
                        d.st = ST_READY;
                    end else begin
                        d.ru = 1'b1;
                        d.st = (frame_rdy_i && !flush_dis_i) ? ST_FLUSH : ST_SUSP;
                    end
                end
            end
            ST_WB: begin
                if (mem_ack_i) begin
                    d.rx_done = q.prev_ls;
                    d.wb_pend = 1'b0;
                    if (d.stop_pend) begin
                        d.st = ST_STOP;
                    end else if (q.nxt_own) begin
                        d.first = 1'b0;
                        d.st    = q.prev_ls ? ST_READY : ST_RECV;
                    end else begin
                        d.ru = 1'b1;
                        d.st = ST_SUSP;
                    end
                end
            end
            ST_READY: begin
                if (d.stop_pend) begin
                    d.st = ST_STOP;
                end else if (frame_rdy_i) begin
                    d.first = 1'b1;
                    d.st    = ST_RECV;
                end
            end
            ST_RECV: begin
                if (d.stop_pend) begin
                    d.st = ST_STOP;
                end else if (seg_done_i) begin
                    d.prev      = q.cur;
                    d.prev_word = q.cur_word;
                    d.prev_fs   = q.first;
                    d.prev_ls   = seg_last_i;
                    d.cur       = next_addr;
                    d.wb_pend   = 1'b1;
                    d.st        = ST_FETCH;
                end
            end
            ST_SUSP: begin
                if (d.stop_pend) begin
                    d.st = ST_STOP;
                end else if (frame_arrive_i || poll_i) begin
                    d.wb_pend = 1'b0;
                    d.st      = ST_FETCH;
                end
            end
            ST_FLUSH: begin
                d.st = ST_FLWAIT;
            end
            ST_FLWAIT: begin
                if (d.stop_pend) begin
                    d.st = ST_STOP;
                end else if (frame_rdy_i) begin
                    d.st = ST_FETCH;
                end else begin
                    d.st = ST_SUSP;
                end
            end
            default: begin
                d.st = ST_STOP;
            end
        endcase

        if (d.st == ST_STOP) begin
            d.stop_pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_STOP, default: '0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        wb_word         = {1'b0, q.prev_word};
        wb_word[FS_BIT] = q.prev_fs;
        wb_word[LS_BIT] = q.prev_ls;
    end

    always_comb begin
        case (q.st)
            ST_STOP:                      vis = VIS_STOP;
            ST_SUSP, ST_FLUSH, ST_FLWAIT: vis = VIS_SUSP;
            default:                      vis = VIS_RUN;
        endcase
    end

    assign mem_req_o     = (q.st == ST_FETCH) || (q.st == ST_WB);
    assign mem_we_o      = (q.st == ST_WB);
    assign mem_addr_o    = (q.st == ST_WB) ? q.prev : q.cur;
    assign mem_wdata_o   = wb_word;
    assign xfer_o        = (q.st == ST_RECV);
    assign flush_o       = (q.st == ST_FLUSH);
    assign state_o       = vis;
    assign rx_done_o     = q.rx_done;
    assign buf_unavail_o = q.ru;
    assign cur_addr_o    = q.cur;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o))); // R13

    AST_DONE_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done_o |-> $past(mem_req_o && mem_we_o && mem_ack_i && mem_wdata_o[LS_BIT])); // R5

    AST_RU_SUSPENDS: assert property (@(posedge clk) disable iff (!rst_n)
        buf_unavail_o |-> (state_o == VIS_SUSP)); // R7

    AST_FLUSH_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> $past(!flush_dis_i)); // R10

    AST_STOP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_o == VIS_STOP) |-> $past(!mem_req_o || mem_ack_i)); // R12
endmodule

// File: tb/rxdesc_engine_tb.sv
module rxdesc_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 16;
    localparam int DB         = 16;
    localparam int MW         = 2;
    localparam int NDESC      = 4;
    localparam logic [15:0] BASE = 16'h0100;

    logic          clk, rst_n;
    logic          start_i, stop_i, poll_i, flush_dis_i;
    logic          frame_arrive_i, frame_rdy_i, seg_done_i, seg_last_i;
    logic          xfer_o, flush_o, mem_req_o, mem_we_o, mem_ack_i;
    logic [AW-1:0] mem_addr_o, cur_addr_o;
    logic [31:0]   mem_wdata_o, mem_rdata_i;
    logic [1:0]    state_o;
    logic          rx_done_o, buf_unavail_o;
    logic [MW-1:0] missed_o;

    rxdesc_engine #(.AW(AW), .DESC_BYTES(DB), .MISS_W(MW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i), .poll_i(poll_i),
        .flush_dis_i(flush_dis_i), .ring_base_i(BASE), .frame_arrive_i(frame_arrive_i),
        .frame_rdy_i(frame_rdy_i), .seg_done_i(seg_done_i), .seg_last_i(seg_last_i),
        .xfer_o(xfer_o), .flush_o(flush_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
        .mem_rdata_i(mem_rdata_i), .state_o(state_o), .rx_done_o(rx_done_o),
        .buf_unavail_o(buf_unavail_o), .missed_o(missed_o), .cur_addr_o(cur_addr_o)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // driven by the main sequence
    int   chk_n = 0, bad_n = 0;
    int   segs = 1, lat = 0, arm_req = 0, pushed_total = 0;
    logic [NDESC-1:0] arm_mask = '0;
    logic rearm = 1'b0;

    // driven by the memory / FIFO model
    logic [31:0] mem [NDESC];
    int   arm_seen = 0, pushed_seen = 0, fifo_n = 0, feed_k = 0, wcnt = 0;
    int   exp_slot = 0, exp_k = 0, wr_cnt = 0, done_cnt = 0, ru_cnt = 0, flush_cnt = 0;
    int   mon_n = 0, mon_bad = 0, idx = 0;
    logic expect_ru = 1'b0;
    logic [AW-1:0] last_rd = '0;
    logic [31:0]   exp_word;
    logic [AW-1:0] exp_addr, exp_rd;

    assign frame_rdy_i = (fifo_n > 0);

    function automatic logic [31:0] armed_word(int i, logic own);
        return ({own, 31'b0}) | ((i == NDESC-1) ? 32'h0000_8000 : 32'h0);
    endfunction

    always @(negedge clk) begin
        if (arm_seen != arm_req) begin
            for (int i = 0; i < NDESC; i++) mem[i] = armed_word(i, arm_mask[i]);
            arm_seen = arm_req;
        end
        if (!rst_n) begin
            fifo_n = 0; pushed_seen = pushed_total; frame_arrive_i = 0;
            seg_done_i = 0; seg_last_i = 0; feed_k = 0; mem_ack_i = 0; mem_rdata_i = '0;
            wcnt = 0; exp_slot = 0; exp_k = 0; wr_cnt = 0; done_cnt = 0; ru_cnt = 0;
            flush_cnt = 0; expect_ru = 0; last_rd = '0;
        end else begin
            if (expect_ru) begin
                mon_n++;
                if (!buf_unavail_o) begin
                    mon_bad++;
                    $display("FAIL R7 buf_unavail one cycle after host-owned read: act=%0d exp=1", buf_unavail_o);
                end
            end
            expect_ru = 1'b0;
            if (buf_unavail_o) ru_cnt++;
            if (rx_done_o) done_cnt++;
            if (flush_o) begin
                flush_cnt++;
                if (fifo_n > 0) fifo_n--;
            end
            frame_arrive_i = 1'b0;
            if (pushed_seen != pushed_total) begin
                fifo_n += pushed_total - pushed_seen;
                pushed_seen = pushed_total;
                frame_arrive_i = 1'b1;
            end
            seg_done_i = 1'b0; seg_last_i = 1'b0;
            if (xfer_o && fifo_n > 0) begin
                seg_done_i = 1'b1;
                if (feed_k == segs - 1) begin
                    seg_last_i = 1'b1; feed_k = 0; fifo_n--;
                end else begin
                    feed_k++;
                end
            end
            mem_ack_i = 1'b0;
            if (mem_req_o) begin
                if (wcnt >= lat) begin
                    wcnt = 0;
                    mem_ack_i = 1'b1;
                    idx = int'((mem_addr_o - BASE) >> 4) & (NDESC - 1);
                    if (mem_we_o) begin
                        // R4 word contents, R6 ring address, R5 read-before-write order
                        exp_addr = BASE + AW'(DB * exp_slot);
                        exp_rd   = BASE + AW'(DB * ((exp_slot + 1) % NDESC));
                        exp_word = ((exp_slot == NDESC-1) ? 32'h8000 : 32'h0)
                                 | ((exp_k == 0) ? 32'h200 : 32'h0)
                                 | ((exp_k == segs - 1) ? 32'h100 : 32'h0);
                        mon_n += 3;
                        if (mem_addr_o != exp_addr) begin
                            mon_bad++;
                            $display("FAIL R6 write-back address: act=%0h exp=%0h", mem_addr_o, exp_addr);
                        end
                        if (mem_wdata_o != exp_word) begin
                            mon_bad++;
                            $display("FAIL R4 write-back word: act=%0h exp=%0h", mem_wdata_o, exp_word);
                        end
                        if (last_rd != exp_rd) begin
                            mon_bad++;
                            $display("FAIL R5 read before write-back: act=%0h exp=%0h", last_rd, exp_rd);
                        end
                        exp_k    = (exp_k == segs - 1) ? 0 : exp_k + 1;
                        exp_slot = (exp_slot + 1) % NDESC;
                        wr_cnt++;
                        mem[idx] = mem_wdata_o;
                        if (rearm) mem[idx] = armed_word(idx, 1'b1);
                    end else begin
                        mem_rdata_i = mem[idx];
                        last_rd = mem_addr_o;
                        if (!mem[idx][31]) expect_ru = 1'b1;
                    end
                end else begin
                    wcnt++;
                end
            end else begin
                wcnt = 0;
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        chk_n++;
        if (act != exp) begin
            bad_n++;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic arm(logic [NDESC-1:0] m);
        arm_mask = m;
        arm_req++;
        cyc(2);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        cyc(1);
        start_i = 1'b0;
    endtask

    task automatic pulse_poll();
        poll_i = 1'b1;
        cyc(1);
        poll_i = 1'b0;
    endtask

    task automatic report();
        $display("test done: total=%0d bad=%0d", chk_n + mon_n, bad_n + mon_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        $display("FAIL watchdog expired");
        bad_n++;
        chk_n++;
        report();
        $finish;
    end

    initial begin
        rst_n = 1'b0; start_i = 0; stop_i = 0; poll_i = 0; flush_dis_i = 0;
        @(negedge clk);
        arm('1);
        do_reset();
        // R1 reset state
        chk("R1 state", int'(state_o), 0);
        chk("R1 req", int'(mem_req_o), 0);
        chk("R1 xfer", int'(xfer_o), 0);
        chk("R1 missed", int'(missed_o), 0);

        // R2..R6: sweep segments per frame, three frames each, ring wraps
        for (int s = 1; s <= 3; s++) begin
            segs = s; rearm = 1'b1; lat = s - 1;
            arm('1);
            do_reset();
            start_i = 1'b1;
            cyc(1);
            start_i = 1'b0;
            chk("R2 read request after start", int'(mem_req_o && !mem_we_o), 1);
            chk("R2 read address", int'(mem_addr_o), int'(BASE));
            cyc(12);
            chk("R3 running holding descriptor", int'(state_o), 1);
            chk("R3 no transfer without frame", int'(xfer_o), 0);
            pushed_total += 3;
            cyc(150);
            chk("R5 receive-complete count", done_cnt, 3);
            chk("R4 descriptors closed", wr_cnt, 3 * s);
            chk("R6 ring position", int'(cur_addr_o), int'(BASE) + DB * ((3 * s) % NDESC));
            chk("R3 frames consumed", fifo_n, 0);
        end
        lat = 0;

        // R7, R8, R10: suspend with flushing disabled, then resume by poll
        segs = 1; rearm = 1'b1; flush_dis_i = 1'b1;
        arm('0);
        do_reset();
        pulse_start();
        cyc(6);
        chk("R7 suspended on host-owned", int'(state_o), 2);
        chk("R7 buffer-unavailable once", ru_cnt, 1);
        chk("R7 position kept", int'(cur_addr_o), int'(BASE));
        pushed_total += 1;
        cyc(12);
        chk("R10 buffer-unavailable again", ru_cnt, 2);
        chk("R10 still suspended", int'(state_o), 2);
        chk("R10 no flush", flush_cnt, 0);
        chk("R10 missed unchanged", int'(missed_o), 0);
        chk("R10 frame still waiting", int'(frame_rdy_i), 1);
        arm('1);
        pulse_poll();
        cyc(20);
        chk("R8 frame received after resume", done_cnt, 1);
        chk("R8 written into retained descriptor", wr_cnt, 1);
        chk("R8 running again", int'(state_o), 1);
        chk("R8 next position", int'(cur_addr_o), int'(BASE) + DB);

        // R9, R11: flushing enabled, several stored frames, saturating count
        flush_dis_i = 1'b0; rearm = 1'b0;
        arm('0);
        do_reset();
        pulse_start();
        cyc(6);
        chk("R9 suspended", int'(state_o), 2);
        pushed_total += 2;
        cyc(30);
        chk("R9 two frames flushed", flush_cnt, 2);
        chk("R9 missed count", int'(missed_o), 2);
        chk("R9 fifo drained", fifo_n, 0);
        chk("R9 back to suspended", int'(state_o), 2);
        chk("R9 buffer-unavailable per read", ru_cnt, 3);
        pushed_total += 3;
        cyc(40);
        chk("R9 five flushed", flush_cnt, 5);
        chk("R11 missed saturates", int'(missed_o), 3);

        // R12, R13: stop during a slow write-back
        segs = 1; rearm = 1'b0; lat = 3;
        arm('1);
        do_reset();
        pulse_start();
        cyc(8);
        pushed_total += 1;
        for (int i = 0; i < 60; i++) begin
            if (mem_req_o && mem_we_o) break;
            cyc(1);
        end
        stop_i = 1'b1;
        cyc(1);
        stop_i = 1'b0;
        chk("R13 write request held", int'(mem_req_o && mem_we_o), 1);
        chk("R12 not stopped during write-back", int'(state_o), 1);
        for (int i = 0; i < 20; i++) begin
            if (!mem_req_o) break;
            cyc(1);
        end
        chk("R12 stopped after write-back", int'(state_o), 0);
        chk("R12 write-back landed own clear", int'(mem[0][31]), 0);
        chk("R12 write-back landed last flag", int'(mem[0][8]), 1);
        cyc(5);
        chk("R12 no request after stop", int'(mem_req_o), 0);
        chk("R12 remains stopped", int'(state_o), 0);

        report();
        $finish;
    end
endmodule